// File: doc/BRIEF.md
# Counter Compare Output Unit

This block sits beside a 32-bit event counter. It compares the running count with a programmed threshold and drives one digital output pin and one status flag. A 2-bit mode input chooses how the pin behaves. It can stay off. It can follow "count at or above threshold". It can follow "count at or below threshold". It can emit a pulse when the count arrives at the threshold.

In pulse mode the width comes from an 8-bit duration, counted in time-base ticks (nominally 1 ms each). A duration of zero means the pin stays high only while the count equals the threshold. An optional main-direction setting lets a pulse start only when the counter arrives at the threshold moving that way. The status flag follows the active comparison condition. It updates only while its enable input is high and otherwise keeps its last value. The counter itself is outside this block.

Top module: `cmp_out_unit`

## Requirements
- R1: With mode_i = 0 (off), out_o is 0 one clock after that mode is applied and stays 0 while it remains, even when the count equals the threshold.
- R2: With mode_i = 1, out_o reflects (cnt_val_i >= cmp_val_i) one clock after the inputs are applied, including the equal case.
- R3: With mode_i = 2, out_o reflects (cnt_val_i <= cmp_val_i) one clock after the inputs are applied, including the equal case.
- R4: With mode_i = 3 and pulse_len_i = N > 0, a clock where cnt_upd_i = 1 and the count equals the threshold (an arrival) sets out_o from the next clock. out_o stays high until N clocks with tick_i = 1 have passed, even if the count moves away. Equality without cnt_upd_i starts no pulse.
- R5: With mode_i = 3 and pulse_len_i = 0, an arrival sets out_o. out_o stays high regardless of ticks and drops one clock after the count differs from the threshold.
- R6: main_dir_i encodes 0 = any direction, 1 = up only, 2 = down only (3 behaves as 0). cnt_dir_i = 1 means counting up. An arrival whose direction does not match starts no pulse.
- R7: A new arrival during an active pulse reloads the full duration.
- R8: While sts_en_i = 1, sts_o takes the condition one clock later: >= in mode 1, <= in mode 2, equality in modes 0 and 3. While sts_en_i = 0, sts_o keeps its value.
- R9: While rst_ni is low, out_o and sts_o are 0.
- R10: Comparisons are unsigned: 0xFFFFFFFF counts as above 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_val_i | input | 32 | Current counter value |
| cnt_dir_i | input | 1 | Counting direction, 1 = up |
| cnt_upd_i | input | 1 | Strobe: counter value changed this clock |
| cmp_val_i | input | 32 | Comparison threshold |
| mode_i | input | 2 | Output mode 0..3 |
| pulse_len_i | input | 8 | Pulse duration in ticks, 0 = hold while equal |
| main_dir_i | input | 2 | Main direction filter for pulse mode |
| tick_i | input | 1 | Time-base tick strobe |
| sts_en_i | input | 1 | Status update enable |
| out_o | output | 1 | Compare output pin |
| sts_o | output | 1 | Compare status flag |

## Verification
The assertions check on every cycle the level modes against the comparator's flags, and the off mode keeping the pin low. They also check that the status flag freezes while disabled and that a pulse never rises without a qualified arrival. They cover blocked wrong-direction arrivals, the dropping of hold-while-equal, and the reloading of the timer. Only the bench scenarios show the full pulse width in ticks and a pulse that outlasts the count leaving the threshold. The same holds for restart extending a pulse, for unsigned ordering at the top of the range, and for the status value held across disabled clocks.

// File: rtl/cmp_out_pkg.sv
package cmp_out_pkg;
  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_GE    = 2'd1,
    MODE_LE    = 2'd2,
    MODE_PULSE = 2'd3
  } out_mode_e;

  typedef enum logic [1:0] {
    DIR_ANY  = 2'd0,
    DIR_UP   = 2'd1,
    DIR_DOWN = 2'd2,
    DIR_RSV  = 2'd3
  } main_dir_e;
endpackage

// File: rtl/cmp_core.sv
module cmp_core #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         eq_o,
  output logic         ge_o,
  output logic         le_o
);
  logic lt;

  assign eq_o = (a_i == b_i);
  assign lt   = (a_i < b_i);   // unsigned
  assign ge_o = ~lt;
  assign le_o = lt | eq_o;
endmodule

// File: rtl/pulse_gen.sv
module pulse_gen #(
  parameter int PW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          evt_i,
  input  logic          eq_i,
  input  logic [PW-1:0] len_i,
  input  logic          tick_i,
  output logic          active_o
);
  logic [PW-1:0] timer_q;
  logic          hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      timer_q <= '0;
      hold_q  <= 1'b0;
    end else if (!en_i) begin
      timer_q <= '0;
      hold_q  <= 1'b0;
    end else if (evt_i) begin
      if (len_i == '0) begin
        hold_q  <= 1'b1;
        timer_q <= '0;
      end else begin
        hold_q  <= 1'b0;
        timer_q <= len_i;
      end
    end else begin
      if (hold_q && !eq_i) hold_q <= 1'b0;
      if (tick_i && timer_q != '0) timer_q <= timer_q - 1'b1;
    end
  end

  assign active_o = hold_q | (timer_q != '0);

  a_r4_rise_needs_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_o) |-> $past(evt_i));

  a_r7_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && evt_i && len_i != '0) |=> (timer_q == $past(len_i)));

  a_r5_hold_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && hold_q && !eq_i && !evt_i) |=> !hold_q);
endmodule

// File: rtl/cmp_out_unit.sv
module cmp_out_unit
  import cmp_out_pkg::*;
#(
  parameter int CW = 32,
  parameter int PW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] cnt_val_i,
  input  logic          cnt_dir_i,
  input  logic          cnt_upd_i,
  input  logic [CW-1:0] cmp_val_i,
  input  logic [1:0]    mode_i,
  input  logic [PW-1:0] pulse_len_i,
  input  logic [1:0]    main_dir_i,
  input  logic          tick_i,
  input  logic          sts_en_i,
  output logic          out_o,
  output logic          sts_o
);
  out_mode_e mode;
  main_dir_e mdir;
  logic eq, ge, le;
  logic dir_ok, arrive, pulse_act;
  logic lvl_q, sts_q, sts_cond;

  assign mode = out_mode_e'(mode_i);
  assign mdir = main_dir_e'(main_dir_i);

  cmp_core #(.W(CW)) u_cmp (
    .a_i (cnt_val_i),
    .b_i (cmp_val_i),
    .eq_o(eq),
    .ge_o(ge),
    .le_o(le)
  );

  always_comb begin
    unique case (mdir)
      DIR_UP:   dir_ok = cnt_dir_i;
      DIR_DOWN: dir_ok = ~cnt_dir_i;
      default:  dir_ok = 1'b1;
    endcase
  end

  assign arrive = cnt_upd_i & eq & dir_ok;

  pulse_gen #(.PW(PW)) u_pulse (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (mode == MODE_PULSE),
    .evt_i   (arrive),
    .eq_i    (eq),
    .len_i   (pulse_len_i),
    .tick_i  (tick_i),
    .active_o(pulse_act)
  );

  always_comb begin
    unique case (mode)
      MODE_GE: sts_cond = ge;
      MODE_LE: sts_cond = le;
      default: sts_cond = eq;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b0;
      sts_q <= 1'b0;
    end else begin
      lvl_q <= (mode == MODE_GE) ? ge : (mode == MODE_LE) ? le : 1'b0;
      if (sts_en_i) sts_q <= sts_cond;
    end
  end

  assign out_o = (mode == MODE_PULSE) ? pulse_act : lvl_q;
  assign sts_o = sts_q;

  a_r1_mode_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_OFF) |=> (mode_i == 2'd3 || !out_o));

  a_r2_ge_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_GE) |=> (mode_i == 2'd3 || out_o == $past(ge)));

  a_r3_le_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_LE) |=> (mode_i == 2'd3 || out_o == $past(le)));

  a_r6_dir_block: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_PULSE && !dir_ok && !pulse_act) |=> (mode_i != 2'd3 || !out_o));

  a_r8_sts_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sts_en_i |=> $stable(sts_o));

  a_r10_unsigned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_GE && cnt_val_i[CW-1] && !cmp_val_i[CW-1]) |=> (mode_i == 2'd3 || out_o));
endmodule

// File: tb/cmp_out_unit_bench.sv
module cmp_out_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cnt = 32'd5, cmpv = 32'd5;
  logic        dir = 1'b1, upd = 1'b0, tick = 1'b0, sen = 1'b1;
  logic [1:0]  mode = 2'd1, mdir = 2'd0;
  logic [7:0]  plen = 8'd3;
  logic        out_w, sts_w;

  int checks = 0, fails = 0;
  bit done = 0;

  typedef struct { int eo; int es; string r; } exp_t;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cmp_out_unit u_cmp_out_unit (
    .clk_i(clk), .rst_ni(rst_n), .cnt_val_i(cnt), .cnt_dir_i(dir),
    .cnt_upd_i(upd), .cmp_val_i(cmpv), .mode_i(mode), .pulse_len_i(plen),
    .main_dir_i(mdir), .tick_i(tick), .sts_en_i(sen),
    .out_o(out_w), .sts_o(sts_w)
  );

  task automatic chk(input int act, input int exp, input string r, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, exp);
    end
  endtask

  // driver: apply one clock of stimulus, queue what the next edge must produce
  task automatic drv(input logic [31:0] c, input logic [31:0] k, input logic [1:0] m,
                     input logic d, input logic u, input logic t, input logic se,
                     input int eo, input int es, input string r);
    exp_t it;
    @(negedge clk);
    cnt = c; cmpv = k; mode = m; dir = d; upd = u; tick = t; sen = se;
    it.eo = eo; it.es = es; it.r = r;
    q.push_back(it);
  endtask

  // monitor
  initial begin
    exp_t it;
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        it = q.pop_front();
        if (it.eo >= 0) chk(int'(out_w), it.eo, it.r, "out");
        if (it.es >= 0) chk(int'(sts_w), it.es, it.r, "sts");
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk(int'(out_w), 0, "R9", "out in reset");
    chk(int'(sts_w), 0, "R9", "sts in reset");
    @(negedge clk);
    rst_n = 1'b1;

    // R1 off mode, status on equality (R8)
    drv(5, 5, 0, 1, 1, 0, 1, 0, 1, "R1");
    // R2 level >=
    drv(9, 5, 1, 1, 0, 0, 1, 1, 1, "R2");
    drv(4, 5, 1, 1, 0, 0, 1, 0, 0, "R2");
    drv(5, 5, 1, 1, 0, 0, 1, 1, 1, "R2");
    // R10 unsigned
    drv(32'hFFFF_FFFF, 1, 1, 1, 0, 0, 1, 1, 1, "R10");
    drv(32'hFFFF_FFFF, 1, 2, 1, 0, 0, 1, 0, 0, "R10");
    // R3 level <=
    drv(3, 5, 2, 1, 0, 0, 1, 1, 1, "R3");
    drv(5, 5, 2, 1, 0, 0, 1, 1, 1, "R3");
    drv(6, 5, 2, 1, 0, 0, 1, 0, 0, "R3");
    // R8 status frozen while disabled
    drv(3, 5, 2, 1, 0, 0, 0, 1, 0, "R8");
    drv(9, 5, 2, 1, 0, 0, 0, 0, 0, "R8");
    drv(3, 5, 2, 1, 0, 0, 1, 1, 1, "R8");
    drv(9, 5, 2, 1, 0, 0, 0, 0, 1, "R8");
    // R4 timed pulse, len 3
    drv(4, 5, 3, 1, 1, 0, 1, 0, 0, "R4");
    drv(5, 5, 3, 1, 1, 0, 1, 1, 1, "R4");
    drv(5, 5, 3, 1, 0, 1, 1, 1, -1, "R4");
    drv(6, 5, 3, 1, 1, 1, 1, 1, 0, "R4");
    drv(6, 5, 3, 1, 0, 1, 1, 0, -1, "R4");
    // R7 restart
    drv(5, 5, 3, 1, 1, 0, 1, 1, -1, "R7");
    drv(5, 5, 3, 1, 0, 1, 1, 1, -1, "R7");
    drv(5, 5, 3, 1, 1, 0, 1, 1, -1, "R7");
    drv(5, 5, 3, 1, 0, 1, 1, 1, -1, "R7");
    drv(5, 5, 3, 1, 0, 1, 1, 1, -1, "R7");
    drv(5, 5, 3, 1, 0, 1, 1, 0, -1, "R7");
    // R4 equality without strobe starts nothing
    drv(5, 5, 3, 1, 0, 0, 1, 0, -1, "R4");
    plen = 8'd0;
    // R5 hold while equal
    drv(5, 5, 3, 1, 1, 0, 1, 1, -1, "R5");
    drv(5, 5, 3, 1, 0, 1, 1, 1, -1, "R5");
    drv(6, 5, 3, 1, 1, 0, 1, 0, -1, "R5");
    plen = 8'd2; mdir = 2'd1;
    // R6 main direction up
    drv(5, 5, 3, 0, 1, 0, 1, 0, -1, "R6");
    drv(4, 5, 3, 0, 1, 0, 1, 0, -1, "R6");
    drv(5, 5, 3, 1, 1, 0, 1, 1, -1, "R6");
    drv(5, 5, 3, 1, 0, 1, 1, 1, -1, "R6");
    drv(5, 5, 3, 1, 0, 1, 1, 0, -1, "R6");
    mdir = 2'd2;
    // R6 main direction down
    drv(5, 5, 3, 1, 1, 0, 1, 0, -1, "R6");
    drv(5, 5, 3, 0, 1, 0, 1, 1, -1, "R6");
    // R1 off mode ignores arrival
    drv(5, 5, 0, 0, 1, 0, 1, 0, 1, "R1");

    repeat (3) @(posedge clk);
    #3;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule